// File: doc/BRIEF.md
# Memory Command Register Interface

This block is the device-side control front end of a byte-wide, electrically reprogrammable memory. It watches a chip-select, output-enable and write-strobe bus that is sampled on the system clock, captures the address when the write strobe falls and the byte when it rises, and turns the accepted bytes into an operating mode: array read, program set-up, programming, program verify, erase set-up, bulk erase and erase verify. It also answers identifier reads when a high-voltage indication is present on the identify line, and it decides when the data bus is driven.

Writes only count while the programming supply is high and the core supply is good. With the programming supply low the block sits in array read, so it behaves as a plain read-only memory. The array itself is outside the block: it receives a read address and returns a byte, and it is told through one-cycle strobes when to start a byte program, when to start a bulk erase and when the running operation has to end.

The bidirectional data pins are split into an input byte, an output byte and an output enable; a pad ring outside the block combines them.

Top module: `mtp_cmd_if`

## Requirements
- R1: While `vpp_hi` is 0 no write changes the mode, and one cycle after `vpp_hi` is seen low the mode is array read; if a program or erase was running at that moment, `arr_stop` pulses for one cycle.
- R2: After reset the mode is array read; while `supply_ok` is 0 completed writes are discarded and the mode does not change.
- R3: A write is the cycle pair in which `we_n` is first sampled low with `ce_n` low and then sampled high; the address is the one present when the low level is first seen, the byte is the one present when the high level is seen, and a strobe that falls while `ce_n` is high is ignored.
- R4: Byte 00h selects array read, in which a read returns `arr_rdata` for the address on `addr`; the mode stays until another accepted write.
- R5: Byte 40h selects program set-up; the next write with a byte other than FFh raises `arr_prog` for one cycle with `arr_waddr` equal to that write's captured address and `arr_wdata` equal to its byte, and the mode becomes programming.
- R6: A write of FFh in program set-up starts no program (no `arr_prog`) but still moves to programming; a second FFh then pulses `arr_stop` and returns to array read, while any other byte pulses `arr_stop` and is decoded as a new command.
- R7: Byte 20h selects erase set-up; a second 20h raises `arr_erase` for one cycle and the mode becomes erasing; any other byte in erase set-up is decoded as a new command.
- R8: Byte A0h (erase verify) or C0h (program verify) stores the address captured with that write; while in either verify mode reads return `arr_rdata` for the stored address, whatever is on `addr`.
- R9: In array read with `id_hv` high, a read returns the manufacturer byte C2h when `addr[0]` is 0 and the device byte 4Fh when it is 1; bit 7 of each is chosen so that the byte holds an odd number of ones. Outside array read `id_hv` has no effect.
- R10: `dout_en` is 1 one cycle after `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled together and 0 otherwise; `dout` is 00h whenever `dout_en` is 0.
- R11: Any byte other than 00h, 20h, 40h, A0h, C0h and FFh that is decoded as a command selects array read; FFh decoded as a command also selects array read.
- R12: An accepted write while programming or erasing pulses `arr_stop` for one cycle, in the cycle the new mode takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Address bus |
| din | input | 8 | Data bus, inbound half |
| dout | output | 8 | Data bus, outbound half (00h when not driving) |
| dout_en | output | 1 | Drive enable for the data pads |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| vpp_hi | input | 1 | Programming supply is at high voltage |
| id_hv | input | 1 | Identify high voltage present on the identify address line |
| supply_ok | input | 1 | Core supply above the safe-write threshold |
| arr_raddr | output | ADDR_W | Array read address |
| arr_rdata | input | 8 | Array read byte for `arr_raddr` |
| arr_waddr | output | ADDR_W | Address of the byte to program |
| arr_wdata | output | 8 | Byte to program |
| arr_prog | output | 1 | One-cycle start of a byte program |
| arr_erase | output | 1 | One-cycle start of a bulk erase |
| arr_stop | output | 1 | One-cycle end of the running program or erase |

## Verification
The assertions take for granted that every bus input is already synchronous to `clk` and that a write strobe stays low for at least one full clock, so each falling and rising edge is seen exactly once and never in the same cycle. The bench changes all inputs only on the falling clock edge, holds `we_n` low for one whole cycle per write, and moves `addr` between the two halves of each write so that capture on the right edge is visible. Supply and identify inputs are changed only between bus cycles.

// File: rtl/mci_pkg.sv
// Package: shared mode encoding, command bytes and identifier helper for
// the memory command register interface. Assumes 8-bit command bytes.
package mci_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_PSETUP  = 3'd1,
        MD_PROG    = 3'd2,
        MD_PVERIFY = 3'd3,
        MD_ESETUP  = 3'd4,
        MD_ERASE   = 3'd5,
        MD_EVERIFY = 3'd6
    } mode_e;

    localparam logic [DATA_W-1:0] CMD_READ    = 8'h00;
    localparam logic [DATA_W-1:0] CMD_PSETUP  = 8'h40;
    localparam logic [DATA_W-1:0] CMD_ESETUP  = 8'h20;
    localparam logic [DATA_W-1:0] CMD_EVERIFY = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_PVERIFY = 8'hC0;
    localparam logic [DATA_W-1:0] CMD_RESET   = 8'hFF;

    // Build an identifier byte: 7-bit code plus a top bit giving odd weight.
    function automatic logic [DATA_W-1:0] id_byte(input logic [DATA_W-2:0] code);
        return {~^code, code};
    endfunction

endpackage

// File: rtl/mci_bus_sampler.sv
// Bus sampler: detects the write strobe edges on the sampled bus, captures
// the address on the falling edge (chip selected) and flags the rising edge
// that completes the write. Assumes inputs are synchronous to clk and that
// the strobe stays low for at least one clock.
module mci_bus_sampler #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_lat,
    output logic              wr_commit
);

    logic we_q;
    logic pend;
    logic fall;

    assign fall      = we_q & ~we_n & ~ce_n;
    assign wr_commit = ~we_q & we_n & pend;

    // Track the strobe level, open a write on the fall, close it on the rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            pend     <= 1'b0;
            addr_lat <= '0;
        end else begin
            we_q <= we_n;
            if (fall) begin
                pend     <= 1'b1;
                addr_lat <= addr;
            end else if (wr_commit) begin
                pend <= 1'b0;
            end
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> $stable(addr_lat)); // R3

    AST_COMMIT_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(fall) || $past(pend)); // R3

endmodule

// File: rtl/mci_mode_fsm.sv
// Mode state machine: decodes completed write bytes into the operating mode
// and issues one-cycle program, erase and stop strobes to the array. Writes
// count only with the programming supply high and the core supply good.
module mci_mode_fsm
    import mci_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_hi,
    input  logic              supply_ok,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr_lat,
    output mode_e             mode,
    output logic [ADDR_W-1:0] vaddr,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase,
    output logic              arr_stop
);

    logic accept;
    logic busy;
    logic is_verify;

    assign accept    = wr_commit & supply_ok;
    assign busy      = (mode == MD_PROG) || (mode == MD_ERASE);
    assign is_verify = (wr_data == CMD_EVERIFY) || (wr_data == CMD_PVERIFY);

    // Map a command byte to the mode it selects; unknown bytes mean read.
    function automatic mode_e decode_cmd(input logic [DATA_W-1:0] b);
        case (b)
            CMD_READ:    return MD_READ;
            CMD_PSETUP:  return MD_PSETUP;
            CMD_ESETUP:  return MD_ESETUP;
            CMD_EVERIFY: return MD_EVERIFY;
            CMD_PVERIFY: return MD_PVERIFY;
            default:     return MD_READ;
        endcase
    endfunction

    // Advance the mode on each accepted write and raise the array strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MD_READ;
            vaddr     <= '0;
            arr_waddr <= '0;
            arr_wdata <= '0;
            arr_prog  <= 1'b0;
            arr_erase <= 1'b0;
            arr_stop  <= 1'b0;
        end else begin
            arr_prog  <= 1'b0;
            arr_erase <= 1'b0;
            arr_stop  <= 1'b0;
            if (!vpp_hi) begin
                mode <= MD_READ;
                if (busy) arr_stop <= 1'b1;
            end else if (accept) begin
                if (busy) arr_stop <= 1'b1;
                if (mode != MD_PSETUP && is_verify) vaddr <= addr_lat;
                case (mode)
                    MD_PSETUP: begin
                        mode <= MD_PROG;
                        if (wr_data != CMD_RESET) begin
                            arr_prog  <= 1'b1;
                            arr_waddr <= addr_lat;
                            arr_wdata <= wr_data;
                        end
                    end
                    MD_ESETUP: begin
                        if (wr_data == CMD_ESETUP) begin
                            mode      <= MD_ERASE;
                            arr_erase <= 1'b1;
                        end else begin
                            mode <= decode_cmd(wr_data);
                        end
                    end
                    default: mode <= decode_cmd(wr_data);
                endcase
            end
        end
    end

    AST_LOWVPP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi |=> mode == MD_READ); // R1

    AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !supply_ok) |=> $stable(mode)); // R2

    AST_PROG_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prog |-> $past(mode) == MD_PSETUP && mode == MD_PROG); // R5

    AST_ERASE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |-> $past(mode) == MD_ESETUP && mode == MD_ERASE); // R7

    AST_STOP_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_stop |-> ($past(mode) == MD_PROG || $past(mode) == MD_ERASE)); // R12

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_prog, arr_erase, arr_stop})); // R12

endmodule

// File: rtl/mci_read_path.sv
// Read path: chooses the array address (live or stored verify address),
// substitutes identifier bytes in read mode under identify high voltage,
// and registers the data bus and its drive enable.
module mci_read_path
    import mci_pkg::*;
#(
    parameter int                ADDR_W    = 17,
    parameter logic [DATA_W-2:0] MFR_CODE7 = 7'h42,
    parameter logic [DATA_W-2:0] DEV_CODE7 = 7'h4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              id_hv,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_raddr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam logic [DATA_W-1:0] MFR_BYTE = id_byte(MFR_CODE7);
    localparam logic [DATA_W-1:0] DEV_BYTE = id_byte(DEV_CODE7);

    logic in_verify;
    logic show_id;
    logic drive;
    logic [DATA_W-1:0] rd_val;

    assign in_verify = (mode == MD_PVERIFY) || (mode == MD_EVERIFY);
    assign show_id   = (mode == MD_READ) && id_hv;
    assign drive     = ~ce_n & ~oe_n & we_n;
    assign arr_raddr = in_verify ? vaddr : addr;

    // Select identifier or array byte for the current read.
    always_comb begin
        if (show_id) rd_val = addr[0] ? DEV_BYTE : MFR_BYTE;
        else         rd_val = arr_rdata;
    end

    // Register the outbound byte and the pad drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= drive;
            dout    <= drive ? rd_val : '0;
        end
    end

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |=> !dout_en && dout == '0); // R10

    AST_ID_ODD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(show_id)) |-> ^dout); // R9

endmodule

// File: rtl/mtp_cmd_if.sv
// Top: command register interface of a byte-wide reprogrammable memory.
// Connects the bus sampler, the mode state machine and the read path.
// Assumes a pad ring outside that merges din/dout/dout_en into one bus.
module mtp_cmd_if
    import mci_pkg::*;
#(
    parameter int                ADDR_W    = 17,
    parameter logic [DATA_W-2:0] MFR_CODE7 = 7'h42,
    parameter logic [DATA_W-2:0] DEV_CODE7 = 7'h4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic              supply_ok,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [7:0]        arr_rdata,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [7:0]        arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase,
    output logic              arr_stop
);

    logic [ADDR_W-1:0] addr_lat;
    logic [ADDR_W-1:0] vaddr;
    logic              wr_commit;
    mode_e             mode;

    mci_bus_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr      (addr),
        .addr_lat  (addr_lat),
        .wr_commit (wr_commit)
    );

    mci_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vpp_hi    (vpp_hi),
        .supply_ok (supply_ok),
        .wr_commit (wr_commit),
        .wr_data   (din),
        .addr_lat  (addr_lat),
        .mode      (mode),
        .vaddr     (vaddr),
        .arr_waddr (arr_waddr),
        .arr_wdata (arr_wdata),
        .arr_prog  (arr_prog),
        .arr_erase (arr_erase),
        .arr_stop  (arr_stop)
    );

    mci_read_path #(
        .ADDR_W    (ADDR_W),
        .MFR_CODE7 (MFR_CODE7),
        .DEV_CODE7 (DEV_CODE7)
    ) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .addr      (addr),
        .vaddr     (vaddr),
        .id_hv     (id_hv),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .arr_rdata (arr_rdata),
        .arr_raddr (arr_raddr),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: tb/mtp_cmd_if_tb.sv
`timescale 1ns/1ps
module mtp_cmd_if_tb;

    localparam int AW = 17;
    // bench-side mode numbers
    localparam int M_RD = 0, M_PS = 1, M_PG = 2, M_PV = 3, M_ES = 4, M_ER = 5, M_EV = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          vpp_hi = 1'b0, id_hv = 1'b0, supply_ok = 1'b1;
    logic [AW-1:0] arr_raddr, arr_waddr;
    logic [7:0]    arr_rdata, arr_wdata;
    logic          arr_prog, arr_erase, arr_stop;

    int n_chk = 0, n_fail = 0;
    int n_prog = 0, n_erase = 0, n_stop = 0;
    logic [AW-1:0] last_wa;
    logic [7:0]    last_wd;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign arr_rdata = mem(arr_raddr);

    mtp_cmd_if #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vpp_hi(vpp_hi), .id_hv(id_hv), .supply_ok(supply_ok),
        .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .arr_waddr(arr_waddr),
        .arr_wdata(arr_wdata), .arr_prog(arr_prog), .arr_erase(arr_erase),
        .arr_stop(arr_stop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_mode;
    bit            m_weq, m_pend;
    logic [AW-1:0] m_alat, m_va;
    logic [7:0]    e_dout;
    bit            e_en, e_prog, e_erase, e_stop;
    logic [AW-1:0] e_wa;
    logic [7:0]    e_wd;

    function automatic int cmd_mode(input logic [7:0] b);
        if (b == 8'h00) return M_RD;
        if (b == 8'h40) return M_PS;
        if (b == 8'h20) return M_ES;
        if (b == 8'hA0) return M_EV;
        if (b == 8'hC0) return M_PV;
        return M_RD;
    endfunction

    always @(posedge clk) begin
        bit commit, fall, en, was_busy;
        logic [7:0] v;
        if (!rst_n) begin
            m_mode = M_RD; m_weq = 1; m_pend = 0; m_alat = '0; m_va = '0;
            e_dout = 0; e_en = 0; e_prog = 0; e_erase = 0; e_stop = 0;
            e_wa = '0; e_wd = '0;
        end else begin
            en = !ce_n && !oe_n && we_n;
            if (m_mode == M_PV || m_mode == M_EV) v = mem(m_va);
            else if (m_mode == M_RD && id_hv) v = addr[0] ? 8'h4F : 8'hC2;
            else v = mem(addr);
            e_en = en;
            e_dout = en ? v : 8'h00;
            e_prog = 0; e_erase = 0; e_stop = 0;
            commit = !m_weq && we_n && m_pend;
            fall = m_weq && !we_n && !ce_n;
            was_busy = (m_mode == M_PG || m_mode == M_ER);
            if (!vpp_hi) begin
                e_stop = was_busy;
                m_mode = M_RD;
            end else if (commit && supply_ok) begin
                e_stop = was_busy;
                if (m_mode == M_PS) begin
                    m_mode = M_PG;
                    if (din != 8'hFF) begin e_prog = 1; e_wa = m_alat; e_wd = din; end
                end else begin
                    if (din == 8'hA0 || din == 8'hC0) m_va = m_alat;
                    if (m_mode == M_ES && din == 8'h20) begin
                        m_mode = M_ER; e_erase = 1;
                    end else m_mode = cmd_mode(din);
                end
            end
            if (fall) begin m_pend = 1; m_alat = addr; end
            else if (commit) m_pend = 0;
            m_weq = we_n;
        end
    end

    // per-clock comparison and strobe bookkeeping, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 dout_en", dout_en, e_en);
            chk("R4/R8/R9 dout", dout, e_dout);
            chk("R5 arr_prog", arr_prog, e_prog);
            chk("R7 arr_erase", arr_erase, e_erase);
            chk("R12 arr_stop", arr_stop, e_stop);
            if (e_prog) begin
                chk("R3 arr_waddr", arr_waddr, e_wa);
                chk("R3 arr_wdata", arr_wdata, e_wd);
            end
            if (arr_prog) begin n_prog++; last_wa = arr_waddr; last_wd = arr_wdata; end
            if (arr_erase) n_erase++;
            if (arr_stop) n_stop++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1; addr = ~a;
        @(negedge clk); ce_n = 1'b1;
        idle(1);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int p0, s0, e0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset dout_en", dout_en, 0);

        // R2: read mode after reset, programming supply low
        rd(17'h00123, v); chk("R2 power-up read", v, mem(17'h00123));

        // R9: identifier bytes
        id_hv = 1'b1;
        rd(17'h0, v); chk("R9 manufacturer byte", v, 8'hC2);
        rd(17'h1, v); chk("R9 device byte", v, 8'h4F);
        id_hv = 1'b0;

        // R1: commands ignored with VPP low
        p0 = n_prog;
        wr(17'h0, 8'h40); wr(17'h100, 8'h3C);
        chk("R1 no program at low vpp", n_prog, p0);

        vpp_hi = 1'b1; idle(1);

        // R5 / R3: program set-up then program
        p0 = n_prog;
        wr(17'h0, 8'h40); wr(17'h1ABC, 8'h3C);
        chk("R5 program strobe", n_prog, p0 + 1);
        chk("R3 captured address", last_wa, 17'h1ABC);
        chk("R3 captured data", last_wd, 8'h3C);

        // R12 / R8: next write ends program, program verify
        s0 = n_stop;
        wr(17'h1ABC, 8'hC0);
        chk("R12 stop after program", n_stop, s0 + 1);
        rd(17'h00005, v); chk("R8 program verify address", v, mem(17'h1ABC));

        // R4: read command and persistence
        wr(17'h0, 8'h00);
        rd(17'h00005, v); chk("R4 read mode", v, mem(17'h00005));
        rd(17'h10F0F, v); chk("R4 read persists", v, mem(17'h10F0F));

        // R6: double FF aborts
        p0 = n_prog; s0 = n_stop;
        wr(17'h0, 8'h40); wr(17'h22, 8'hFF);
        chk("R6 null data no program", n_prog, p0);
        chk("R6 first FF no stop", n_stop, s0);
        wr(17'h33, 8'hFF);
        chk("R6 second FF stops", n_stop, s0 + 1);
        wr(17'h44, 8'h3C);
        chk("R6 back in read, no program", n_prog, p0);

        // R6: other byte after null data is a command
        wr(17'h0, 8'h40); wr(17'h22, 8'hFF); wr(17'h77, 8'hA0);
        rd(17'h0, v); chk("R6 command after null data", v, mem(17'h77));

        // R7 / R8: erase
        e0 = n_erase; s0 = n_stop;
        wr(17'h0, 8'h20); wr(17'h0, 8'h20);
        chk("R7 erase strobe", n_erase, e0 + 1);
        wr(17'h9, 8'hA0);
        chk("R12 stop after erase", n_stop, s0 + 1);
        rd(17'h100, v); chk("R8 erase verify address", v, mem(17'h9));

        // R9: identify has no effect outside read
        id_hv = 1'b1;
        rd(17'h0, v); chk("R9 no id in verify", v, mem(17'h9));
        id_hv = 1'b0;

        // R7: erase set-up followed by another command
        e0 = n_erase;
        wr(17'h0, 8'h20); wr(17'h0, 8'h00);
        chk("R7 no erase", n_erase, e0);
        rd(17'h42, v); chk("R7 read after set-up abandon", v, mem(17'h42));

        // R11: unknown byte selects read
        wr(17'h55, 8'hA0); wr(17'h0, 8'h77);
        rd(17'h66, v); chk("R11 unknown byte reads", v, mem(17'h66));

        // R2: lockout with supply low
        supply_ok = 1'b0;
        wr(17'h55, 8'hA0);
        supply_ok = 1'b1;
        rd(17'h66, v); chk("R2 locked write ignored", v, mem(17'h66));
        p0 = n_prog;
        supply_ok = 1'b0; wr(17'h0, 8'h40); supply_ok = 1'b1;
        wr(17'h10, 8'h12);
        chk("R2 locked set-up ignored", n_prog, p0);

        // R3: strobe falling with chip deselected is ignored
        p0 = n_prog;
        @(negedge clk); din = 8'h40; ce_n = 1'b1; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        idle(1);
        wr(17'h10, 8'h12);
        chk("R3 deselected write ignored", n_prog, p0);

        // R1: VPP drop ends erase and forces read
        e0 = n_erase; s0 = n_stop;
        wr(17'h0, 8'h20); wr(17'h0, 8'h20);
        chk("R7 erase again", n_erase, e0 + 1);
        @(negedge clk); vpp_hi = 1'b0;
        idle(2);
        chk("R1 stop on vpp drop", n_stop, s0 + 1);
        vpp_hi = 1'b1;
        wr(17'h9, 8'hA0);
        @(negedge clk); vpp_hi = 1'b0;
        idle(2); vpp_hi = 1'b1;
        rd(17'h100, v); chk("R1 verify left on vpp drop", v, mem(17'h100));

        // R10: bus released with OE high or WE low
        @(negedge clk); addr = 17'h3; ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); chk("R10 output disable", dout_en, 0);
        oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk); chk("R10 write strobe low", dout_en, 0);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        idle(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule